// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address presented to a synchronous burst memory array. On a rising clock edge it captures an external address whenever either of its two load strobes is high. One strobe is meant for the processor side and one for the controller side, and both act the same way. After a load, an advance input steps the two least significant address bits through a four-beat burst. The upper bits stay where the load placed them.

The stepping order is chosen when the burst is loaded. With the order select low, the low bits follow an interleaved pattern: the starting low bits are XORed with the beat count. With the order select high, the low bits count upward from the starting value and wrap modulo four. Low is the default level, so an order input tied off low gives interleaved order.

The burst feature is optional. A host may load a fresh address on every clock and never assert advance, and it loses no cycle by doing so. The memory array, the data path and any power control sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active, and after it is released, `word_addr` is zero, the beat count is zero and interleaved order is selected.
- R2: When `load_cpu` or `load_ctl` (or both) is high at a rising edge, `word_addr` equals the `addr_in` sampled at that edge from just after the edge onward.
- R3: At an edge where both load strobes and `advance` are low, `word_addr` keeps its value, whatever `addr_in` and `order_linear` do.
- R4: In interleaved order (`order_linear` = 0 at load), each edge with `advance` high and no load steps the beat count by one. The low two bits of `word_addr` then equal the loaded low bits XOR the beat count.
- R5: In linear order (`order_linear` = 1 at load), the low two bits of `word_addr` equal the loaded low bits plus the beat count, modulo 4.
- R6: After four advances with no load, `word_addr` returns to the loaded address, in either order.
- R7: When a load strobe and `advance` are both high at the same edge, the load takes effect, the beat count restarts at zero and `word_addr` equals `addr_in`.
- R8: Address bits 2 and above change only on a load. Carry out of the two-bit counter never reaches them.
- R9: `order_linear` is sampled only at a load edge. Changing it during a burst has no effect on the order until the next load.
- R10: Loads on consecutive edges each take effect, so a new address appears on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W (19) | External word address |
| load_cpu | input | 1 | Processor-side load strobe |
| load_ctl | input | 1 | Controller-side load strobe |
| advance | input | 1 | Step the burst by one beat |
| order_linear | input | 1 | 1 = linear order, 0 = interleaved (default) |
| word_addr | output | ADDR_W (19) | Current word address to the array |

## Verification
Every result has a latency of exactly one register. A load, an advance or a hold sampled at edge N appears on `word_addr` just after edge N, and the value stays steady until edge N+1. The bench drives inputs on the falling edge and reads `word_addr` two nanoseconds after the next rising edge. Each vector is therefore judged on the edge that consumed it, before the next vector's inputs are applied. The vector walk holds the inputs steady across that edge, so no idle cycle is inserted between consecutive loads or advances.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Burst ordering selected at load time; low level is the default.
    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

endpackage

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [CNT_W-1:0] beat_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] beat_d;

    // Load restarts the beat; step only counts when no load is present.
    always_comb begin
        beat_d = beat_q;
        if (load) begin
            beat_d = '0;
        end else if (step) begin
            beat_d = beat_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    // R4: an advance without a load moves the beat by one
    p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (beat_q == $past(beat_q) + ONE));

    // R7: a load restarts the beat even if step is also high
    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == '0));

    // R3: idle cycles keep the beat count
    p_beat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(beat_q));

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_low,
    input  logic [CNT_W-1:0] beat,
    input  burst_order_e     order,
    output logic [CNT_W-1:0] low_out
);

    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] ilv_low;

    // Interleaved order: bitwise XOR of start and beat.
    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_low[b] = start_low[b] ^ beat[b];
    end

    // Linear order: modular sum; carry out of the top bit is dropped.
    assign lin_low = start_low + beat;

    always_comb begin
        unique case (order)
            ORD_LINEAR:     low_out = lin_low;
            ORD_INTERLEAVE: low_out = ilv_low;
            default:        low_out = ilv_low;
        endcase
    end

    // With a zero beat both orders must reproduce the start bits.
    always_comb begin
        if (beat == '0) begin
            a_zero_beat_identity: assert (low_out == start_low);
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              load_cpu,
    input  logic              load_ctl,
    input  logic              advance,
    input  logic              order_linear,
    output logic [ADDR_W-1:0] word_addr
);

    localparam int HI_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        burst_order_e      order;
    } seq_state_t;

    seq_state_t       st_d, st_q;
    logic             any_load;
    logic [CNT_W-1:0] beat;
    logic [CNT_W-1:0] low_bits;

    assign any_load = load_cpu | load_ctl;

    // Next-state: base address and burst order are captured only on a load.
    always_comb begin
        st_d = st_q;
        if (any_load) begin
            st_d.base  = addr_in;
            st_d.order = order_linear ? ORD_LINEAR : ORD_INTERLEAVE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.base  <= '0;
            st_q.order <= ORD_INTERLEAVE;
        end else begin
            st_q <= st_d;
        end
    end

    bas_beat_ctr #(
        .CNT_W (CNT_W)
    ) u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (any_load),
        .step   (advance),
        .beat_q (beat)
    );

    bas_order_map #(
        .CNT_W (CNT_W)
    ) u_map (
        .start_low (st_q.base[CNT_W-1:0]),
        .beat      (beat),
        .order     (st_q.order),
        .low_out   (low_bits)
    );

    assign word_addr = {st_q.base[ADDR_W-1:CNT_W], low_bits};

    // R2: either strobe captures the external address at that edge
    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_load |=> (word_addr == $past(addr_in)));

    // R3: no load and no advance holds the output
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_load && !advance) |=> $stable(word_addr));

    // R8: upper bits move only with a load
    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_load |=> $stable(word_addr[ADDR_W-1:CNT_W]));

    // R9: order select is ignored between loads
    p_order_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_load |=> $stable(st_q.order));

    // R1: reset leaves the address at zero
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (word_addr == '0));

    initial begin
        a_width_ok: assert (HI_W > 0);
    end

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

    localparam int AW = 19;
    localparam int NV = 19;

    typedef struct packed {
        logic          lc;
        logic          lt;
        logic          adv;
        logic          lin;
        logic [AW-1:0] addr;
        logic [AW-1:0] exp;
        logic [3:0]    req;
    } vec_t;

    // Expected values derived by hand from the requirements.
    localparam vec_t [0:NV-1] VEC = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 19'h12346, 19'h12346, 4'd2},  // R2 cpu load, low=2
        '{1'b0, 1'b0, 1'b1, 1'b0, 19'h00000, 19'h12347, 4'd4},  // R4 2^1=3
        '{1'b0, 1'b0, 1'b1, 1'b0, 19'h00000, 19'h12344, 4'd4},  // R4 2^2=0
        '{1'b0, 1'b0, 1'b0, 1'b1, 19'h7FFFF, 19'h12344, 4'd3},  // R3 idle hold
        '{1'b0, 1'b0, 1'b1, 1'b1, 19'h00000, 19'h12345, 4'd9},  // R9 lin ignored, 2^3=1
        '{1'b0, 1'b0, 1'b1, 1'b0, 19'h00000, 19'h12346, 4'd6},  // R6 wrap to start
        '{1'b0, 1'b1, 1'b0, 1'b1, 19'h7FFFD, 19'h7FFFD, 4'd2},  // R2 ctl load, linear
        '{1'b0, 1'b0, 1'b1, 1'b1, 19'h00000, 19'h7FFFE, 4'd5},  // R5 1+1
        '{1'b0, 1'b0, 1'b1, 1'b1, 19'h00000, 19'h7FFFF, 4'd5},  // R5 1+2
        '{1'b0, 1'b0, 1'b1, 1'b1, 19'h00000, 19'h7FFFC, 4'd8},  // R8 no carry upward
        '{1'b0, 1'b0, 1'b1, 1'b0, 19'h00000, 19'h7FFFD, 4'd6},  // R6 wrap, R9 order kept
        '{1'b1, 1'b0, 1'b1, 1'b0, 19'h00A03, 19'h00A03, 4'd7},  // R7 load beats advance
        '{1'b0, 1'b0, 1'b1, 1'b0, 19'h00000, 19'h00A02, 4'd7},  // R7 beat restarted: 3^1
        '{1'b1, 1'b1, 1'b1, 1'b1, 19'h55551, 19'h55551, 4'd7},  // R7 both strobes + adv
        '{1'b1, 1'b0, 1'b0, 1'b0, 19'h00010, 19'h00010, 4'd10}, // R10 back-to-back
        '{1'b0, 1'b1, 1'b0, 1'b0, 19'h00021, 19'h00021, 4'd10}, // R10
        '{1'b1, 1'b0, 1'b0, 1'b1, 19'h3FFFF, 19'h3FFFF, 4'd10}, // R10
        '{1'b0, 1'b0, 1'b1, 1'b1, 19'h00000, 19'h3FFFC, 4'd8},  // R8 linear wrap 3+1
        '{1'b0, 1'b0, 1'b0, 1'b0, 19'h12345, 19'h3FFFC, 4'd3}   // R3 addr_in ignored
    };

    logic          clk;
    logic          rst_n;
    logic [AW-1:0] addr_in;
    logic          load_cpu;
    logic          load_ctl;
    logic          advance;
    logic          order_linear;
    logic [AW-1:0] word_addr;

    int n_run;
    int n_fail;
    bit done;

    burst_addr_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_in      (addr_in),
        .load_cpu     (load_cpu),
        .load_ctl     (load_ctl),
        .advance      (advance),
        .order_linear (order_linear),
        .word_addr    (word_addr)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input int req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: word_addr=%h expected=%h", req, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic drive_step(input logic lc, input logic lt, input logic adv,
                              input logic lin, input logic [AW-1:0] a,
                              input logic [AW-1:0] exp, input int req);
        load_cpu = lc; load_ctl = lt; advance = adv; order_linear = lin; addr_in = a;
        @(posedge clk);
        #2;
        check(req, word_addr, exp);
        @(negedge clk);
    endtask

    initial begin
        n_run = 0; n_fail = 0; done = 1'b0;
        rst_n = 1'b0; addr_in = '0; load_cpu = 1'b0; load_ctl = 1'b0;
        advance = 1'b0; order_linear = 1'b0;
        repeat (3) @(negedge clk);
        check(1, word_addr, '0);  // R1 during reset
        rst_n = 1'b1;
        // R1: after reset, interleaved order from zero: one advance gives 0^1=1
        drive_step(1'b0, 1'b0, 1'b1, 1'b1, 19'h00000, 19'h00001, 1);

        for (int i = 0; i < NV; i++) begin
            drive_step(VEC[i].lc, VEC[i].lt, VEC[i].adv, VEC[i].lin,
                       VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
        end

        // R4 full interleaved walk from low bits 1: 1,0,3,2, then R6 back to 1
        drive_step(1'b1, 1'b0, 1'b0, 1'b0, 19'h40001, 19'h40001, 4);
        drive_step(1'b0, 1'b0, 1'b1, 1'b0, 19'h00000, 19'h40000, 4);
        drive_step(1'b0, 1'b0, 1'b1, 1'b0, 19'h00000, 19'h40003, 4);
        drive_step(1'b0, 1'b0, 1'b1, 1'b0, 19'h00000, 19'h40002, 4);
        drive_step(1'b0, 1'b0, 1'b1, 1'b0, 19'h00000, 19'h40001, 6);

        // R1: reset mid-burst returns to zero
        drive_step(1'b0, 1'b0, 1'b1, 1'b0, 19'h00000, 19'h40000, 4);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check(1, word_addr, '0);
        @(negedge clk);
        rst_n = 1'b1;
        drive_step(1'b0, 1'b0, 1'b0, 1'b0, 19'h7FFFF, 19'h00000, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule